// File: doc/BRIEF.md
# Event Mapping Command Executor

This block carries out the two commands that bind a (device, event) pair to an interrupt number and a collection. Both forms carry the event and the collection. The full form also carries an explicit interrupt number. The short form uses the event number as the interrupt number. Once a command is started, the block fetches the command's second and third doublewords over a shared memory port. It then asks a lookup port for the device's table entry and runs every range check. If all checks pass, it writes a two-word translation entry into the device's translation table.

A command that fails any check is dropped. Nothing is written and no fault is raised: the block reports "dropped" and the queue logic moves on. A memory or lookup error aborts the command at once and is reported separately. Queue pointer handling and the table walk behind the lookup port belong to the neighbouring logic.

Top module: `emx_exec`

## Requirements
- R1: After `start`, the block makes a 64-bit read at `cmd_addr+8`, then a 64-bit read at `cmd_addr+16`, then a lookup request carrying the captured `dev_id`. Only one of `mem_req` and `lkp_req` is ever high at a time.
- R2: The event ID is bits [31:0] of the first doubleword read. The full form takes the interrupt number from bits [63:32] of that doubleword. The collection ID is bits [15:0] of the second doubleword read, and its upper bits are ignored.
- R3: The short form (`full_form`=0) encodes the event ID as the interrupt number and skips the interrupt range check.
- R4: The low word is 64 bits and is written with `mem_wide`=1. Its layout is: bit 0 = 1 (valid), bit 1 = 1 (physical), bits [25:2] = interrupt number bits [23:0], bits [35:26] = 1023, bits [63:36] = 0.
- R5: The high word is 32 bits and is written with `mem_wide`=0. Its bits [15:0] hold the collection ID and all other bits of `mem_wdata` are 0.
- R6: The table base is the device entry's bits [ADDR_W-3:6] shifted left by 8. The low word goes to base + event×8 and the high word to base + (event+8)×4, both modulo 2^ADDR_W. The low word is written first.
- R7: The command is dropped when any of these holds: the device ID exceeds `cfg_max_devid`; the collection ID exceeds `cfg_max_collid`; device entry bit 0 (valid) is 0; the event ID exceeds 2^(entry[5:1]+1). An event ID equal to that limit is accepted.
- R8: A full-form command is dropped when its interrupt number is below 8192 or above 2^(`cfg_id_bits`+1). The values 8192 and 2^(`cfg_id_bits`+1) themselves are accepted.
- R9: A dropped command makes no write and ends with `status`=1.
- R10: An error flag on any read, lookup or write ends the command immediately with `status`=2. No further memory or lookup request follows it.
- R11: `done` is a one-cycle pulse. A completed command reports `status`=0. A `start` that arrives while a command is in progress is ignored. After reset, `done`, `mem_req` and `lkp_req` are 0.
- R12: A request is held high, with a stable address and kind, until its acknowledge arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a command (taken only when idle) |
| full_form | input | 1 | 1 = explicit interrupt number, 0 = short form |
| dev_id | input | DEVID_W | Device ID from the command's first doubleword |
| cmd_addr | input | ADDR_W | Address of the command in the queue |
| cfg_max_devid | input | DEVID_W | Largest legal device ID |
| cfg_max_collid | input | 16 | Largest legal collection ID |
| cfg_id_bits | input | 5 | Interrupt ID width code |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_wide | output | 1 | 1 = 64-bit access, 0 = 32-bit access |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 64 | Write data |
| mem_ack | input | 1 | Request completed |
| mem_err | input | 1 | Completed with error (valid with `mem_ack`) |
| mem_rdata | input | 64 | Read data (valid with `mem_ack`) |
| lkp_req | output | 1 | Device entry lookup request |
| lkp_devid | output | DEVID_W | Device to look up |
| lkp_ack | input | 1 | Lookup completed |
| lkp_err | input | 1 | Lookup failed (valid with `lkp_ack`) |
| lkp_entry | input | ADDR_W-2 | Used bits [ADDR_W-3:0] of the device entry |
| done | output | 1 | Command finished (one cycle) |
| status | output | 2 | 0 executed, 1 dropped, 2 memory error |

## Verification
The hardest cases to reach are the ones where the command dies partway through: an error on the third, fourth or fifth transaction of a command that would otherwise pass. These must show that no later request is issued and that the right status code comes out. The stimulus reaches them by having the memory and lookup models count served transactions within each command and raise the error flag on a chosen step, while the scoreboard holds only the transactions up to that step. The range checks are also driven exactly at each limit and one past it. This pins down the "greater than", not "greater or equal", comparisons on event and interrupt numbers.

// File: rtl/emx_pkg.sv
package emx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_EV, ST_RD_COL, ST_LOOKUP, ST_CHECK, ST_WR_LO, ST_WR_HI
  } emx_state_e;

  localparam logic [1:0] EMX_OK      = 2'd0;
  localparam logic [1:0] EMX_DROPPED = 2'd1;
  localparam logic [1:0] EMX_MEMERR  = 2'd2;

  localparam int            INTNUM_W = 24;
  localparam int            COLL_W   = 16;
  localparam logic [9:0]    SPURIOUS = 10'd1023;

  typedef struct packed {
    logic [31:0] int_num;
    logic [31:0] event_id;
  } emx_dw2_t;
endpackage

// File: rtl/emx_field_check.sv
module emx_field_check
  import emx_pkg::*;
#(
  parameter int DEVID_W  = 32,
  parameter int ADDR_W   = 52,
  parameter int LPI_BASE = 8192
) (
  input  logic                full_form,
  input  logic [DEVID_W-1:0]  dev_id,
  input  logic [63:0]         dw2,
  input  logic [COLL_W-1:0]   coll_in,
  input  logic [ADDR_W-3:0]   dte,
  input  logic [DEVID_W-1:0]  max_devid,
  input  logic [COLL_W-1:0]   max_collid,
  input  logic [4:0]          id_bits,
  output logic                accept,
  output logic [31:0]         event_id,
  output logic [31:0]         int_num
);
  localparam int NCHK = 5;

  emx_dw2_t    f2;
  logic [32:0] ev_limit;
  logic [32:0] int_limit;
  logic [NCHK-1:0] reject;

  assign f2        = emx_dw2_t'(dw2);
  assign event_id  = f2.event_id;
  assign int_num   = full_form ? f2.int_num : f2.event_id;
  assign ev_limit  = 33'd1 << ({1'b0, dte[5:1]} + 6'd1);
  assign int_limit = 33'd1 << ({1'b0, id_bits} + 6'd1);

  always_comb begin
    reject[0] = dev_id > max_devid;
    reject[1] = coll_in > max_collid;
    reject[2] = ~dte[0];
    reject[3] = {1'b0, f2.event_id} > ev_limit;
    reject[4] = full_form &&
                ((f2.int_num < 32'(LPI_BASE)) || ({1'b0, f2.int_num} > int_limit));
  end

  assign accept = ~|reject;
endmodule

// File: rtl/emx_entry_build.sv
module emx_entry_build
  import emx_pkg::*;
#(
  parameter int ADDR_W = 52
) (
  input  logic [ADDR_W-3:0]   dte,
  input  logic [31:0]         event_id,
  input  logic [INTNUM_W-1:0] int_num,
  input  logic [COLL_W-1:0]   coll_id,
  output logic [63:0]         lo_word,
  output logic [31:0]         hi_word,
  output logic [ADDR_W-1:0]   lo_addr,
  output logic [ADDR_W-1:0]   hi_addr
);
  localparam int ITT_W = ADDR_W - 8;

  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] ev_ext;

  assign base    = {dte[6 +: ITT_W], 8'h00};
  assign ev_ext  = ADDR_W'(event_id);
  assign lo_addr = base + (ev_ext << 3);
  assign hi_addr = base + ((ev_ext + ADDR_W'(8)) << 2);
  assign lo_word = {28'd0, SPURIOUS, int_num, 1'b1, 1'b1};
  assign hi_word = {{(32-COLL_W){1'b0}}, coll_id};
endmodule

// File: rtl/emx_exec.sv
module emx_exec
  import emx_pkg::*;
#(
  parameter int ADDR_W   = 52,
  parameter int DEVID_W  = 32,
  parameter int LPI_BASE = 8192
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                full_form,
  input  logic [DEVID_W-1:0]  dev_id,
  input  logic [ADDR_W-1:0]   cmd_addr,
  input  logic [DEVID_W-1:0]  cfg_max_devid,
  input  logic [15:0]         cfg_max_collid,
  input  logic [4:0]          cfg_id_bits,
  output logic                mem_req,
  output logic                mem_we,
  output logic                mem_wide,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [63:0]         mem_wdata,
  input  logic                mem_ack,
  input  logic                mem_err,
  input  logic [63:0]         mem_rdata,
  output logic                lkp_req,
  output logic [DEVID_W-1:0]  lkp_devid,
  input  logic                lkp_ack,
  input  logic                lkp_err,
  input  logic [ADDR_W-3:0]   lkp_entry,
  output logic                done,
  output logic [1:0]          status
);
  emx_state_e          state;
  logic                form_q;
  logic [ADDR_W-1:0]   base_q;
  logic [63:0]         dw2_q;
  logic [COLL_W-1:0]   coll_q;
  logic [ADDR_W-3:0]   dte_q;

  logic                accept;
  logic [31:0]         event_id;
  logic [31:0]         int_num;
  logic [63:0]         lo_word;
  logic [31:0]         hi_word;
  logic [ADDR_W-1:0]   lo_addr;
  logic [ADDR_W-1:0]   hi_addr;

  emx_field_check #(.DEVID_W(DEVID_W), .ADDR_W(ADDR_W), .LPI_BASE(LPI_BASE)) u_check (
    .full_form (form_q),
    .dev_id    (lkp_devid),
    .dw2       (dw2_q),
    .coll_in   (coll_q),
    .dte       (dte_q),
    .max_devid (cfg_max_devid),
    .max_collid(cfg_max_collid),
    .id_bits   (cfg_id_bits),
    .accept    (accept),
    .event_id  (event_id),
    .int_num   (int_num)
  );

  emx_entry_build #(.ADDR_W(ADDR_W)) u_build (
    .dte     (dte_q),
    .event_id(event_id),
    .int_num (int_num[INTNUM_W-1:0]),
    .coll_id (coll_q),
    .lo_word (lo_word),
    .hi_word (hi_word),
    .lo_addr (lo_addr),
    .hi_addr (hi_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      form_q    <= 1'b0;
      base_q    <= '0;
      dw2_q     <= '0;
      coll_q    <= '0;
      dte_q     <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_wide  <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      lkp_req   <= 1'b0;
      lkp_devid <= '0;
      done      <= 1'b0;
      status    <= EMX_OK;
    end else begin
      case (state)
        ST_IDLE: begin
          done <= 1'b0;
          if (start) begin
            form_q    <= full_form;
            base_q    <= cmd_addr;
            lkp_devid <= dev_id;
            mem_req   <= 1'b1;
            mem_we    <= 1'b0;
            mem_wide  <= 1'b1;
            mem_addr  <= cmd_addr + ADDR_W'(8);
            state     <= ST_RD_EV;
          end
        end
        ST_RD_EV: begin
          if (mem_ack) begin
            if (mem_err) begin
              mem_req <= 1'b0;
              done    <= 1'b1;
              status  <= EMX_MEMERR;
              state   <= ST_IDLE;
            end else begin
              dw2_q    <= mem_rdata;
              mem_addr <= base_q + ADDR_W'(16);
              state    <= ST_RD_COL;
            end
          end
        end
        ST_RD_COL: begin
          if (mem_ack) begin
            mem_req <= 1'b0;
            if (mem_err) begin
              done   <= 1'b1;
              status <= EMX_MEMERR;
              state  <= ST_IDLE;
            end else begin
              coll_q  <= mem_rdata[COLL_W-1:0];
              lkp_req <= 1'b1;
              state   <= ST_LOOKUP;
            end
          end
        end
        ST_LOOKUP: begin
          if (lkp_ack) begin
            lkp_req <= 1'b0;
            if (lkp_err) begin
              done   <= 1'b1;
              status <= EMX_MEMERR;
              state  <= ST_IDLE;
            end else begin
              dte_q <= lkp_entry;
              state <= ST_CHECK;
            end
          end
        end
        ST_CHECK: begin
          if (!accept) begin
            done   <= 1'b1;
            status <= EMX_DROPPED;
            state  <= ST_IDLE;
          end else begin
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_wide  <= 1'b1;
            mem_addr  <= lo_addr;
            mem_wdata <= lo_word;
            state     <= ST_WR_LO;
          end
        end
        ST_WR_LO: begin
          if (mem_ack) begin
            if (mem_err) begin
              mem_req <= 1'b0;
              done    <= 1'b1;
              status  <= EMX_MEMERR;
              state   <= ST_IDLE;
            end else begin
              mem_wide  <= 1'b0;
              mem_addr  <= hi_addr;
              mem_wdata <= {32'd0, hi_word};
              state     <= ST_WR_HI;
            end
          end
        end
        ST_WR_HI: begin
          if (mem_ack) begin
            mem_req <= 1'b0;
            done    <= 1'b1;
            status  <= mem_err ? EMX_MEMERR : EMX_OK;
            state   <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/emx_exec_chk.sv
module emx_exec_chk #(
  parameter int ADDR_W = 52
) (
  input logic              clk,
  input logic              rst,
  input logic              done,
  input logic [1:0]        status,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_wide,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [63:0]       mem_wdata,
  input logic              mem_ack,
  input logic              lkp_req,
  input logic              lkp_ack
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R11
  AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (rst)
    done |-> status != 2'd3); // R11
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wide)); // R12
  AST_LKP_HOLD: assert property (@(posedge clk) disable iff (rst)
    lkp_req && !lkp_ack |=> lkp_req); // R12
  AST_PORTS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(mem_req && lkp_req)); // R1
  AST_LO_FORMAT: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_we && mem_wide |->
      mem_wdata[1:0] == 2'b11 && mem_wdata[35:26] == 10'd1023 && mem_wdata[63:36] == '0); // R4
  AST_HI_FORMAT: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_we && !mem_wide |-> mem_wdata[63:16] == '0); // R5
  AST_LO_ALIGN: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_we && mem_wide |-> mem_addr[2:0] == 3'd0); // R6
endmodule

bind emx_exec emx_exec_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .done     (done),
  .status   (status),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_wide (mem_wide),
  .mem_addr (mem_addr),
  .mem_wdata(mem_wdata),
  .mem_ack  (mem_ack),
  .lkp_req  (lkp_req),
  .lkp_ack  (lkp_ack)
);

// File: tb/emx_exec_test.sv
`timescale 1ns/1ps
module emx_exec_test;
  localparam int ADDR_W  = 52;
  localparam int DEVID_W = 32;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic               rst;
  logic               start;
  logic               full_form;
  logic [DEVID_W-1:0] dev_id;
  logic [ADDR_W-1:0]  cmd_addr;
  logic [DEVID_W-1:0] cfg_max_devid;
  logic [15:0]        cfg_max_collid;
  logic [4:0]         cfg_id_bits;
  logic               mem_req, mem_we, mem_wide;
  logic [ADDR_W-1:0]  mem_addr;
  logic [63:0]        mem_wdata;
  logic               mem_ack, mem_err;
  logic [63:0]        mem_rdata;
  logic               lkp_req;
  logic [DEVID_W-1:0] lkp_devid;
  logic               lkp_ack, lkp_err;
  logic [ADDR_W-3:0]  lkp_entry;
  logic               done;
  logic [1:0]         status;

  emx_exec #(.ADDR_W(ADDR_W), .DEVID_W(DEVID_W)) uut (
    .clk(clk), .rst(rst), .start(start), .full_form(full_form), .dev_id(dev_id),
    .cmd_addr(cmd_addr), .cfg_max_devid(cfg_max_devid), .cfg_max_collid(cfg_max_collid),
    .cfg_id_bits(cfg_id_bits), .mem_req(mem_req), .mem_we(mem_we), .mem_wide(mem_wide),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err),
    .mem_rdata(mem_rdata), .lkp_req(lkp_req), .lkp_devid(lkp_devid), .lkp_ack(lkp_ack),
    .lkp_err(lkp_err), .lkp_entry(lkp_entry), .done(done), .status(status)
  );

  typedef struct {
    bit                we;
    bit                wide;
    logic [ADDR_W-1:0] addr;
    logic [63:0]       data;
    string             tag;
  } op_t;

  op_t         exp_ops[$];
  logic [1:0]  exp_stat[$];
  string       stat_tag[$];
  int          n_cmp = 0;
  int          n_bad = 0;
  int          step;
  int          err_at;
  int          rd_n;
  int          lat;
  logic [ADDR_W-1:0] held_addr;
  logic [63:0] cur_dw2, cur_dw3;
  logic [ADDR_W-3:0] cur_dte;
  logic [31:0] exp_devid;
  bit          done_seen;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // memory model: acknowledges after a short wait, compares against the scoreboard
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
      mem_err = 1'b0;
      lat     = 0;
    end else if (mem_req && !rst) begin
      if (lat == 0) held_addr = mem_addr;
      if (lat < 1 + (step % 2)) lat++;
      else begin
        step++;
        chk(mem_addr == held_addr, "R12", "address moved while waiting", 64'(mem_addr), 64'(held_addr));
        if (exp_ops.size() == 0) begin
          chk(1'b0, "R9", "unexpected memory request", 64'(mem_addr), 64'd0);
        end else begin
          op_t e;
          e = exp_ops.pop_front();
          chk(mem_we == e.we && mem_wide == e.wide, e.tag, "access kind",
              {62'd0, mem_we, mem_wide}, {62'd0, e.we, e.wide});
          chk(mem_addr == e.addr, e.tag, "address", 64'(mem_addr), 64'(e.addr));
          if (e.we) chk(mem_wdata == e.data, e.tag, "write data", mem_wdata, e.data);
        end
        if (!mem_we) begin
          mem_rdata = (rd_n == 0) ? cur_dw2 : cur_dw3;
          rd_n++;
        end
        mem_err = (step == err_at);
        mem_ack = 1'b1;
      end
    end
  end

  // lookup model
  always @(negedge clk) begin
    if (lkp_ack) begin
      lkp_ack = 1'b0;
      lkp_err = 1'b0;
    end else if (lkp_req && !rst) begin
      step++;
      chk(step == 3, "R1", "lookup order", 64'(step), 64'd3);
      chk(lkp_devid == exp_devid, "R1", "lookup device", 64'(lkp_devid), 64'(exp_devid));
      lkp_entry = cur_dte;
      lkp_err   = (step == err_at);
      lkp_ack   = 1'b1;
    end
  end

  // completion monitor
  always @(negedge clk) begin
    if (done && !rst) begin
      done_seen = 1'b1;
      if (exp_stat.size() == 0) chk(1'b0, "R11", "unexpected done", 64'(status), 64'd0);
      else begin
        logic [1:0] s;
        string t;
        s = exp_stat.pop_front();
        t = stat_tag.pop_front();
        chk(status == s, t, "status", 64'(status), 64'(s));
      end
    end
  end

  function automatic logic [ADDR_W-3:0] mk_dte(input bit v, input logic [4:0] sz,
                                               input logic [ADDR_W-9:0] tbl);
    return {tbl, sz, v};
  endfunction

  function automatic op_t mk_op(input bit we, input bit wide, input logic [63:0] a,
                                input logic [63:0] d, input string tag);
    op_t o;
    o.we = we; o.wide = wide; o.addr = a[ADDR_W-1:0]; o.data = d; o.tag = tag;
    return o;
  endfunction

  task automatic run_cmd(input string tag, input bit full, input logic [31:0] devid,
                         input logic [ADDR_W-1:0] caddr, input logic [63:0] dw2,
                         input logic [63:0] dw3, input logic [ADDR_W-3:0] dte,
                         input int err, input bit poke);
    logic [31:0] ev, inum;
    logic [15:0] col;
    logic [63:0] base, lo_a, hi_a, lo_w, hi_w;
    bit          drop;
    int          wait_n;
    begin
      cur_dw2 = dw2; cur_dw3 = dw3; cur_dte = dte; exp_devid = devid;
      step = 0; rd_n = 0; err_at = err; done_seen = 0;
      ev   = dw2[31:0];
      inum = full ? dw2[63:32] : ev;
      col  = dw3[15:0];
      drop = (devid > cfg_max_devid) || (col > cfg_max_collid) || !dte[0] ||
             ({32'd0, ev} > (64'd1 << (dte[5:1] + 1))) ||
             (full && ((inum < 32'd8192) || ({32'd0, inum} > (64'd1 << (cfg_id_bits + 1)))));
      base = 64'({dte[ADDR_W-3:6], 8'h00});
      lo_a = base + 64'(ev) * 8;
      hi_a = base + (64'(ev) + 8) * 4;
      lo_w = {28'd0, 10'd1023, inum[23:0], 2'b11};
      hi_w = {48'd0, col};
      exp_ops.push_back(mk_op(0, 1, 64'(caddr) + 8, 0, "R1"));
      if (err == 1) begin exp_stat.push_back(2'd2); stat_tag.push_back(tag); end
      else begin
        exp_ops.push_back(mk_op(0, 1, 64'(caddr) + 16, 0, "R1"));
        if (err == 2 || err == 3) begin exp_stat.push_back(2'd2); stat_tag.push_back(tag); end
        else if (drop) begin exp_stat.push_back(2'd1); stat_tag.push_back(tag); end
        else begin
          exp_ops.push_back(mk_op(1, 1, lo_a, lo_w, "R4"));
          if (err == 4) begin exp_stat.push_back(2'd2); stat_tag.push_back(tag); end
          else begin
            exp_ops.push_back(mk_op(1, 0, hi_a, hi_w, "R6"));
            exp_stat.push_back(err == 5 ? 2'd2 : 2'd0);
            stat_tag.push_back(tag);
          end
        end
      end
      @(negedge clk);
      full_form = full; dev_id = devid; cmd_addr = caddr; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (poke) begin
        @(negedge clk);
        dev_id = devid ^ 32'd1; cmd_addr = caddr + 52'h100; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
      wait_n = 0;
      while (!done_seen && wait_n < 500) begin
        @(negedge clk);
        wait_n++;
      end
      chk(done_seen, tag, "command completed", 64'(done_seen), 64'd1);
      repeat (4) @(negedge clk);
      chk(exp_ops.size() == 0, tag, "memory requests left unissued", 64'(exp_ops.size()), 64'd0);
      chk(step == ((err != 0) ? err : (drop ? 3 : 5)), tag, "transaction count",
          64'(step), 64'((err != 0) ? err : (drop ? 3 : 5)));
      exp_ops.delete();
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst = 1'b1; start = 1'b0; full_form = 1'b0; dev_id = '0; cmd_addr = '0;
    cfg_max_devid = 32'd100; cfg_max_collid = 16'd20; cfg_id_bits = 5'd15;
    mem_ack = 1'b0; mem_err = 1'b0; mem_rdata = '0;
    lkp_ack = 1'b0; lkp_err = 1'b0; lkp_entry = '0; lat = 0; step = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: idle outputs after reset
    chk(!done && !mem_req && !lkp_req, "R11", "reset state",
        {61'd0, done, mem_req, lkp_req}, 64'd0);

    // R2: full form, upper bits of the third doubleword ignored
    run_cmd("R2", 1, 32'd5, 52'h1000, {32'd9000, 32'd3}, 64'hFFFF_0000_ABCD_0007,
            mk_dte(1, 5'd4, 44'h12345), 0, 0);
    // R3: short form, interrupt number from event, no LPI range check
    run_cmd("R3", 0, 32'd6, 52'h2000, {32'hFFFF_FFFF, 32'd17}, 64'd3,
            mk_dte(1, 5'd6, 44'h00777), 0, 0);
    // R7: device ID limit
    run_cmd("R7", 1, 32'd101, 52'h3000, {32'd9000, 32'd1}, 64'd1, mk_dte(1, 5'd4, 44'h1), 0, 0);
    run_cmd("R7", 1, 32'd100, 52'h3000, {32'd9000, 32'd1}, 64'd1, mk_dte(1, 5'd4, 44'h1), 0, 0);
    // R7: collection limit
    run_cmd("R7", 1, 32'd2, 52'h3040, {32'd9000, 32'd1}, 64'd21, mk_dte(1, 5'd4, 44'h2), 0, 0);
    run_cmd("R7", 1, 32'd2, 52'h3040, {32'd9000, 32'd1}, 64'd20, mk_dte(1, 5'd4, 44'h2), 0, 0);
    // R9: invalid device entry dropped, no write
    run_cmd("R9", 1, 32'd2, 52'h3080, {32'd9000, 32'd1}, 64'd2, mk_dte(0, 5'd4, 44'h2), 0, 0);
    // R7: event limit 2^(2+1) = 8
    run_cmd("R7", 1, 32'd3, 52'h30C0, {32'd9000, 32'd9}, 64'd2, mk_dte(1, 5'd2, 44'h3), 0, 0);
    run_cmd("R7", 1, 32'd3, 52'h30C0, {32'd9000, 32'd8}, 64'd2, mk_dte(1, 5'd2, 44'h3), 0, 0);
    // R8: interrupt number bounds 8192 .. 65536
    run_cmd("R8", 1, 32'd4, 52'h3100, {32'd8191, 32'd1}, 64'd2, mk_dte(1, 5'd4, 44'h4), 0, 0);
    run_cmd("R8", 1, 32'd4, 52'h3100, {32'd8192, 32'd1}, 64'd2, mk_dte(1, 5'd4, 44'h4), 0, 0);
    run_cmd("R8", 1, 32'd4, 52'h3100, {32'd65536, 32'd1}, 64'd2, mk_dte(1, 5'd4, 44'h4), 0, 0);
    run_cmd("R8", 1, 32'd4, 52'h3100, {32'd65537, 32'd1}, 64'd2, mk_dte(1, 5'd4, 44'h4), 0, 0);
    // R4: interrupt number wider than the entry field, large event, address wrap
    cfg_id_bits = 5'd31;
    run_cmd("R4", 1, 32'd9, 52'h4000, {32'h0123_4567, 32'h8000_0000}, 64'd11,
            mk_dte(1, 5'd31, 44'hFFF_FFFF_FFFF), 0, 0);
    cfg_id_bits = 5'd15;
    // R5 / R6: another layout with a distinct base
    run_cmd("R5", 1, 32'd0, 52'h5000, {32'd12345, 32'd0}, 64'd0, mk_dte(1, 5'd0, 44'hABC), 0, 0);
    // R10: error on each transaction in turn
    for (int k = 1; k <= 5; k++)
      run_cmd("R10", 1, 32'd7, 52'h6000, {32'd9000, 32'd5}, 64'd4, mk_dte(1, 5'd4, 44'h55), k, 0);
    // R11: start while busy is ignored
    run_cmd("R11", 1, 32'd8, 52'h7000, {32'd10000, 32'd6}, 64'd5, mk_dte(1, 5'd4, 44'h66), 0, 1);
    chk(exp_stat.size() == 0, "R11", "pending completions", 64'(exp_stat.size()), 64'd0);
    finish_run();
  end
endmodule